// File: doc/BRIEF.md
# Dual-Channel Compare-Match Interval Timer

This block holds two independent 16-bit interval timers behind one synchronous 16-bit register bus. Each channel has an up-counter that advances once per period of its own prescaled clock. When the counter reaches the channel's compare value it restarts from zero, so the channel fires at a fixed interval of (compare + 1) prescaled ticks. A single shared start register switches counting on or off for each channel. On every match the channel can emit a one-cycle interrupt pulse.

Software sets a channel up by choosing a prescale setting, an interrupt enable and a compare value. It then sets the channel's start bit. Software may write the counter and compare value at any time to shift or reshape the interval. Only aligned 16-bit accesses are decoded.

Top module: `dual_match_timer`

## Requirements
- R1: After reset the start register reads 0, both control registers read 0, both counters read 0, and both compare registers read 0xFFFF.
- R2: The start register is at offset 0. Bit 0 runs channel 0 and bit 1 runs channel 1. A read returns only those two bits, with bits 15:2 reading 0.
- R3: A control register keeps only bits 1:0 (prescale setting) and bit 6 (interrupt enable). All other bits read 0, so writing 0xFFFF reads back as 0x0043.
- R4: A prescale setting s makes the counter advance once every D = 2^(3+2s) system clocks (8, 32, 128, 512). The first advance lands D clocks after the edge that sets the start bit.
- R5: On a prescaled tick where the counter equals the compare value C, the counter loads 0 instead of incrementing. After a start from 0, the counter therefore reads floor(n/D) mod (C+1) at n clocks after the start edge.
- R6: On a match with the interrupt enable set, the channel's interrupt output is high for exactly one clock, beginning at the edge where the counter clears. That is (C+1)·D clocks after a start from 0. With the enable clear, no pulse appears.
- R7: While a channel's start bit is 0, its counter keeps its value and no matches occur. Its prescaler is held at zero, so after a restart the next advance comes a full D clocks later.
- R8: A bus write to a counter takes priority over a coincident prescaled tick, and that tick produces no match. Counter and compare writes govern every following count and match decision.
- R9: The register map is: channel 0 at offsets 2 (control), 4 (counter) and 6 (compare); channel 1 at offsets 8, 10 and 12. Reads of any other offset, including odd offsets, return 0. Writes to those offsets change nothing.
- R10: Each channel counts, matches and interrupts only according to its own registers and start bit. The other channel's interrupt stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busAddr | input | 4 | Byte offset of the addressed register |
| busWrEn | input | 1 | Write strobe, sampled at the rising clock edge |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Read data for busAddr, combinational |
| irqOut | output | 2 | Per-channel compare-match interrupt pulse |

## Verification
The main sweep tries every prescale setting on both channels with compare values 0, 1, 2 and 4. During each run it traces the counter on every clock against floor(n/D) mod (C+1). This separates a wrong divider, an off-by-one clear (wrap at C versus C+1) and a missing clear. The same runs time each interrupt pulse and measure its width, and they check that the idle channel stays silent. Directed patterns cover four further cases:
- A stop followed by a restart exposes a prescaler that keeps its phase.
- A counter write timed onto a tick shows which source wins.
- A compare value moved just ahead of the running count confirms that the new value is used.
- Writes of all ones to every register show which bits are stored.

// File: rtl/mtim_pkg.sv
package mtim_pkg;
  localparam int NUM_CH     = 2;
  localparam int DATA_W     = 16;
  localparam int ADDR_W     = 4;
  localparam int DIV_SEL_W  = 2;
  localparam int DIV_BASE   = 3;
  localparam int DIV_STEP   = 2;
  localparam int PRE_W      = DIV_BASE + DIV_STEP * ((1 << DIV_SEL_W) - 1);
  localparam int IRQ_EN_BIT = 6;
  localparam int CH_BASE    = 2;
  localparam int CH_STRIDE  = 6;
  localparam int CNT_OFS    = 2;
  localparam int CMP_OFS    = 4;
  localparam logic [DATA_W-1:0] CMP_RESET = '1;

  typedef struct packed {
    logic                 run;
    logic                 irqEn;
    logic [DIV_SEL_W-1:0] divSel;
    logic                 cntWr;
    logic                 cmpWr;
  } chanStrobe_t;
endpackage

// File: rtl/mtim_chan_dp.sv
module mtim_chan_dp
  import mtim_pkg::*;
#(
  parameter int CNT_W  = DATA_W,
  parameter int SEL_W  = DIV_SEL_W,
  parameter int PSC_W  = PRE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  chanStrobe_t       strobe,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  cnt,
  output logic [CNT_W-1:0]  cmp,
  output logic              irqOut
);
  localparam int NUM_SEL = 1 << SEL_W;

  logic [PSC_W-1:0] preCnt;
  logic [PSC_W-1:0] divLast;
  logic             tick;
  logic             match;

  always_comb begin
    divLast = '0;
    for (int s = 0; s < NUM_SEL; s++) begin
      if (strobe.divSel == SEL_W'(s)) begin
        divLast = PSC_W'((1 << (DIV_BASE + DIV_STEP * s)) - 1);
      end
    end
  end

  assign tick  = strobe.run && (preCnt >= divLast);
  assign match = tick && (cnt == cmp) && !strobe.cntWr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      preCnt <= '0;
    end else if (!strobe.run || tick) begin
      preCnt <= '0;
    end else begin
      preCnt <= preCnt + PSC_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (strobe.cntWr) begin
      cnt <= wrData;
    end else if (match) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp <= CMP_RESET;
    end else if (strobe.cmpWr) begin
      cmp <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irqOut <= 1'b0;
    end else begin
      irqOut <= match && strobe.irqEn;
    end
  end

  assert_irq_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irqOut |=> !irqOut);

  assert_irq_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irqOut |-> $past(strobe.irqEn));

  assert_hold_when_stopped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe.run && !strobe.cntWr) |=> (cnt == $past(cnt)));

  assert_clear_on_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (cnt == cmp) && !strobe.cntWr) |=> (cnt == '0));

  assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.cntWr |=> ((cnt == $past(cnt)) || (cnt == $past(cnt) + CNT_W'(1)) || (cnt == '0)));

  assert_write_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.cntWr |=> (cnt == $past(wrData)));
endmodule

// File: rtl/mtim_ctrl.sv
module mtim_ctrl
  import mtim_pkg::*;
#(
  parameter int CH    = NUM_CH,
  parameter int DW    = DATA_W,
  parameter int AW    = ADDR_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [AW-1:0]         busAddr,
  input  logic                  busWrEn,
  input  logic [DW-1:0]         busWrData,
  input  logic [CH-1:0][DW-1:0] chanCnt,
  input  logic [CH-1:0][DW-1:0] chanCmp,
  output chanStrobe_t [CH-1:0]  strobes,
  output logic [DW-1:0]         busRdData
);
  logic [CH-1:0]                runReg;
  logic [CH-1:0][DIV_SEL_W-1:0] divSelReg;
  logic [CH-1:0]                irqEnReg;
  logic                         startHit;
  logic [CH-1:0]                hitCtrl;
  logic [CH-1:0]                hitCnt;
  logic [CH-1:0]                hitCmp;

  assign startHit = (busAddr == '0);

  always_comb begin
    for (int c = 0; c < CH; c++) begin
      hitCtrl[c] = (busAddr == AW'(CH_BASE + CH_STRIDE * c));
      hitCnt[c]  = (busAddr == AW'(CH_BASE + CH_STRIDE * c + CNT_OFS));
      hitCmp[c]  = (busAddr == AW'(CH_BASE + CH_STRIDE * c + CMP_OFS));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      runReg <= '0;
    end else if (busWrEn && startHit) begin
      runReg <= busWrData[CH-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      divSelReg <= '0;
      irqEnReg  <= '0;
    end else begin
      for (int c = 0; c < CH; c++) begin
        if (busWrEn && hitCtrl[c]) begin
          divSelReg[c] <= busWrData[DIV_SEL_W-1:0];
          irqEnReg[c]  <= busWrData[IRQ_EN_BIT];
        end
      end
    end
  end

  always_comb begin
    for (int c = 0; c < CH; c++) begin
      strobes[c].run    = runReg[c];
      strobes[c].irqEn  = irqEnReg[c];
      strobes[c].divSel = divSelReg[c];
      strobes[c].cntWr  = busWrEn && hitCnt[c];
      strobes[c].cmpWr  = busWrEn && hitCmp[c];
    end
  end

  always_comb begin
    busRdData = '0;
    if (startHit) begin
      busRdData[CH-1:0] = runReg;
    end
    for (int c = 0; c < CH; c++) begin
      if (hitCtrl[c]) begin
        busRdData[DIV_SEL_W-1:0] = divSelReg[c];
        busRdData[IRQ_EN_BIT]    = irqEnReg[c];
      end
      if (hitCnt[c]) busRdData = chanCnt[c];
      if (hitCmp[c]) busRdData = chanCmp[c];
    end
  end

  assert_start_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    startHit |-> (busRdData[DW-1:CH] == '0));

  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!startHit && (hitCtrl == '0) && (hitCnt == '0) && (hitCmp == '0)) |-> (busRdData == '0));

  assert_start_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busWrEn && startHit) |=> (runReg == $past(busWrData[CH-1:0])));
endmodule

// File: rtl/dual_match_timer.sv
module dual_match_timer
  import mtim_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic [NUM_CH-1:0] irqOut
);
  chanStrobe_t [NUM_CH-1:0]         strobes;
  logic [NUM_CH-1:0][DATA_W-1:0]    chanCnt;
  logic [NUM_CH-1:0][DATA_W-1:0]    chanCmp;

  mtim_ctrl #(
    .CH (NUM_CH),
    .DW (DATA_W),
    .AW (ADDR_W)
  ) i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .chanCnt   (chanCnt),
    .chanCmp   (chanCmp),
    .strobes   (strobes),
    .busRdData (busRdData)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    mtim_chan_dp #(
      .CNT_W (DATA_W),
      .SEL_W (DIV_SEL_W),
      .PSC_W (PRE_W)
    ) i_dp (
      .clk    (clk),
      .rst_n  (rst_n),
      .strobe (strobes[c]),
      .wrData (busWrData),
      .cnt    (chanCnt[c]),
      .cmp    (chanCmp[c]),
      .irqOut (irqOut[c])
    );
  end
endmodule

// File: tb/test_dual_match_timer.sv
module test_dual_match_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [15:0] busWrData = '0;
  logic [15:0] busRdData;
  logic [1:0]  irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  dual_match_timer i_dual_match_timer (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .irqOut(irqOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input int addr, input int data);
    @(negedge clk);
    busAddr = 4'(addr); busWrData = 16'(data); busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input int addr, output int data);
    busAddr = 4'(addr);
    #1;
    data = int'(busRdData);
  endtask

  function automatic int ctrlAddr(input int ch); return 2 + 6*ch; endfunction
  function automatic int cntAddr(input int ch);  return 4 + 6*ch; endfunction
  function automatic int cmpAddr(input int ch);  return 6 + 6*ch; endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset values
    busRead(0, rd); check(rd == 0, "R1 start", rd, 0);
    for (int ch = 0; ch < 2; ch++) begin
      busRead(ctrlAddr(ch), rd); check(rd == 0, "R1 ctrl", rd, 0);
      busRead(cntAddr(ch), rd);  check(rd == 0, "R1 cnt", rd, 0);
      busRead(cmpAddr(ch), rd);  check(rd == 16'hFFFF, "R1 cmp", rd, 16'hFFFF);
    end

    // R3: stored control bits
    for (int ch = 0; ch < 2; ch++) begin
      busWrite(ctrlAddr(ch), 16'hFFFF);
      busRead(ctrlAddr(ch), rd); check(rd == 16'h0043, "R3 ctrl mask", rd, 16'h0043);
      busWrite(ctrlAddr(ch), 0);
    end
    // R2: start readback
    busWrite(0, 16'hFFFF);
    busRead(0, rd); check(rd == 3, "R2 start mask", rd, 3);
    busWrite(0, 0);

    // R9: unmapped offsets
    busWrite(cmpAddr(0), 16'h1234);
    busWrite(14, 16'hBEEF);
    busWrite(5, 16'hBEEF);
    busRead(14, rd); check(rd == 0, "R9 read 14", rd, 0);
    busRead(1, rd);  check(rd == 0, "R9 read odd", rd, 0);
    busRead(cmpAddr(0), rd); check(rd == 16'h1234, "R9 write ignored", rd, 16'h1234);
    busRead(cmpAddr(1), rd); check(rd == 16'hFFFF, "R9 map ch1 cmp", rd, 16'hFFFF);

    // R4 R5 R6 R10: sweep of channel, prescale and compare
    for (int ch = 0; ch < 2; ch++) begin
      for (int s = 0; s < 4; s++) begin
        for (int ci = 0; ci < 4; ci++) begin
          int cv, d, p, hits, badIrq, cntBad, otherIrq, firstBad;
          cv = (ci == 3) ? 4 : ci;
          d = 1 << (3 + 2*s);
          p = (cv + 1) * d;
          busWrite(0, 0);
          busWrite(ctrlAddr(ch), (1 << 6) | s);
          busWrite(cmpAddr(ch), cv);
          busWrite(cntAddr(ch), 0);
          busWrite(0, 1 << ch);
          busAddr = 4'(cntAddr(ch));
          hits = 0; badIrq = 0; cntBad = 0; otherIrq = 0; firstBad = -1;
          for (int n = 1; n <= 2*p + 1; n++) begin
            @(negedge clk); #1;
            if (int'(busRdData) != (n / d) % (cv + 1)) begin
              cntBad++;
              if (firstBad < 0) firstBad = int'(busRdData);
            end
            if (irqOut[ch]) begin
              hits++;
              if (n != p && n != 2*p) badIrq++;
            end
            if (irqOut[1-ch]) otherIrq++;
          end
          check(cntBad == 0, "R4 R5 count trace", firstBad, 0);
          check(hits == 2 && badIrq == 0, "R6 pulse timing", hits, 2);
          check(otherIrq == 0, "R10 other channel quiet", otherIrq, 0);
        end
      end
    end
    busWrite(0, 0);

    // R6: enable clear gives no pulse, count still clears
    begin
      int seen = 0;
      busWrite(ctrlAddr(0), 0);
      busWrite(cmpAddr(0), 1);
      busWrite(cntAddr(0), 0);
      busWrite(0, 1);
      for (int n = 1; n <= 40; n++) begin
        @(negedge clk); #1;
        if (irqOut[0]) seen++;
      end
      check(seen == 0, "R6 disabled no pulse", seen, 0);
      busRead(cntAddr(0), rd); check(rd == 1, "R5 clear without irq", rd, 1);
      busWrite(0, 0);
    end

    // R7: stop holds, restart waits a full period
    busWrite(ctrlAddr(0), 16'h0040);
    busWrite(cmpAddr(0), 1000);
    busWrite(cntAddr(0), 0);
    busWrite(0, 1);
    repeat (50) @(negedge clk);
    busWrite(0, 0);
    busRead(cntAddr(0), rd); check(rd == 6, "R7 stop value", rd, 6);
    repeat (100) @(negedge clk);
    busRead(cntAddr(0), rd); check(rd == 6, "R7 hold", rd, 6);
    busWrite(0, 1);
    repeat (7) @(negedge clk);
    busRead(cntAddr(0), rd); check(rd == 6, "R7 prescaler restart", rd, 6);
    @(negedge clk);
    busRead(cntAddr(0), rd); check(rd == 7, "R7 first tick", rd, 7);
    busWrite(0, 0);

    // R8: counter write on a tick wins; new compare takes effect
    begin
      int wait48 = -1;
      busWrite(ctrlAddr(1), 16'h0040);
      busWrite(cmpAddr(1), 1000);
      busWrite(cntAddr(1), 0);
      busWrite(0, 2);
      repeat (15) @(negedge clk);
      busAddr = 4'(cntAddr(1)); busWrData = 16'd500; busWrEn = 1'b1;
      @(negedge clk);
      busWrEn = 1'b0;
      busRead(cntAddr(1), rd); check(rd == 500, "R8 write wins", rd, 500);
      repeat (8) @(negedge clk);
      busRead(cntAddr(1), rd); check(rd == 501, "R8 count after write", rd, 501);
      busWrite(cmpAddr(1), 503);
      for (int n = 27; n <= 60; n++) begin
        @(negedge clk); #1;
        if (irqOut[1] && wait48 < 0) wait48 = n;
      end
      check(wait48 == 48, "R8 new compare match", wait48, 48);
      busWrite(0, 0);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule